// File: doc/BRIEF.md
# Two-Byte RC4 Keystream Generator

This block turns an already scheduled 256-entry byte permutation into RC4 keystream. Each iteration runs two rounds of the generation loop in one step. The two index increments, the two dependent swaps and both output addresses are resolved combinationally from the current state and committed in a single clock edge. The two addresses can be formed before the swaps land because a swap leaves the sum of the two exchanged entries unchanged. A second pipeline stage then reads both keystream bytes from the permutation as it stands after the double swap.

The permutation is held in a register array inside the block. Key scheduling elsewhere fills it through a byte-wide load port. The indices start at zero after reset. While `en` is high, the block starts one iteration every second clock, and each iteration yields a 16-bit word. Combining the keystream with data is left to the user.

Top module: `rc4_dual_keystream`

## Requirements
- R1: Synchronous active-high reset clears both indices to zero and holds `ks_valid` low. With `en` low, no word is produced afterwards.
- R2: While `ld_we` is high, the entry at `ld_addr` takes `ld_data` on the clock edge. No iteration starts while `ld_we` is high, even if `en` is high.
- R3: The words form the RC4 keystream of the loaded permutation, starting from indices i = j = 0. The earlier byte of each pair is placed in `ks_data[7:0]` and the later byte in `ks_data[15:8]`. For the permutation scheduled from the 3-byte key 4B 65 79, the first two words are 16'h9FEB and 16'h8177.
- R4: An iteration starts at a rising edge where `en` is sampled high, and its word is presented with `ks_valid` after the next rising edge. This makes the first word of a burst visible after two rising edges with `en` high.
- R5: With `en` held high, iterations start on alternate edges beginning with the first. `ks_valid` therefore pulses for exactly one cycle in every two, which gives an average of one keystream byte per clock.
- R6: With `en` low, the indices and the permutation are frozen. A word already in the second stage is still delivered. Resuming continues the sequence with no byte lost or repeated. An interrupted issue cadence restarts on the first edge at which `en` is high again.
- R7: Output matches sequential single-round execution in every index-collision case. These cases are: equal swap targets (i1 = j1 or i2 = j2), i2 = j1, j2 = i1, and output addresses that hit a slot touched by the second swap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Allow keystream iterations |
| ld_we | input | 1 | Write strobe for the permutation load port |
| ld_addr | input | 8 | Permutation entry to write |
| ld_data | input | 8 | Value written to the permutation entry |
| ks_valid | output | 1 | One-cycle pulse qualifying `ks_data` |
| ks_data | output | 16 | Keystream pair: earlier byte low, later byte high |

## Verification
RC4 state errors propagate fast and without limit. A single wrong index or a misplaced swap entry changes the next few keystream bytes and alters every later byte with high probability. A comparison of each word against a sequential model therefore exposes the fault within a few words of where it occurs. Collision-handling faults appear only when the specific index coincidences happen. For that reason, crafted permutations force the equal-target, i2 = j1 and j2 = i1 cases in the first iteration after reset. A long run on the identity and on scheduled permutations covers the output-address forwarding. Cadence and freeze faults appear at once as an extra, missing or adjacent `ks_valid` pulse, or as a word shifted by one position in the expected sequence.

// File: rtl/rc4ks_pkg.sv
package rc4ks_pkg;

    parameter int unsigned SYM_W    = 8;
    localparam int unsigned SBOX_N  = 1 << SYM_W;
    localparam int unsigned WR_PORTS = 4;
    localparam int unsigned PAIR_W  = 2 * SYM_W;

    typedef logic [SYM_W-1:0] sym_t;

    // One write request from the double-swap stage
    typedef struct packed {
        logic en;
        sym_t addr;
        sym_t data;
    } wr_req_t;

    // Everything stage two needs to read both bytes
    typedef struct packed {
        sym_t z1_addr;
        sym_t z2_addr;
        sym_t i2;
        sym_t j2;
        sym_t s1_i2;   // entry at i2 after the first swap only
        sym_t s1_j2;   // entry at j2 after the first swap only
    } fetch_t;

    // Value of slot 'addr' given two pending overrides; kb wins over ka
    function automatic sym_t fwd2(input sym_t addr,
                                  input sym_t ka, input sym_t va,
                                  input sym_t kb, input sym_t vb,
                                  input sym_t raw);
        if (addr == kb)      return vb;
        else if (addr == ka) return va;
        else                 return raw;
    endfunction

endpackage

// File: rtl/rc4ks_state_array.sv
module rc4ks_state_array
    import rc4ks_pkg::*;
(
    input  logic    clk,
    input  logic    ld_we,
    input  sym_t    ld_addr,
    input  sym_t    ld_data,
    input  wr_req_t wr [WR_PORTS],
    output sym_t    st [SBOX_N]
);

    // Load port has priority; swap writes apply in order, later ones win
    always_ff @(posedge clk) begin
        if (ld_we) begin
            st[ld_addr] <= ld_data;
        end else begin
            for (int k = 0; k < WR_PORTS; k++) begin
                if (wr[k].en) st[wr[k].addr] <= wr[k].data;
            end
        end
    end

endmodule

// File: rtl/rc4ks_round_pair.sv
module rc4ks_round_pair
    import rc4ks_pkg::*;
(
    input  logic    go,
    input  sym_t    i_cur,
    input  sym_t    j_cur,
    input  sym_t    st [SBOX_N],
    output wr_req_t wr [WR_PORTS],
    output sym_t    i_next,
    output sym_t    j_next,
    output fetch_t  fetch
);

    sym_t i1, j1, i2, j2;
    sym_t a, b, x, y;
    sym_t sum1, sum2;

    always_comb begin
        // first round on the original state
        i1 = i_cur + sym_t'(1);
        a  = st[i1];
        j1 = j_cur + a;
        b  = st[j1];
        // second round sees slots i1 and j1 already exchanged
        i2 = i_cur + sym_t'(2);
        x  = fwd2(i2, i1, b, j1, a, st[i2]);
        j2 = j1 + x;
        y  = fwd2(j2, i1, b, j1, a, st[j2]);
        // sums are swap-invariant, so addresses are final already
        sum1 = a + b;
        sum2 = x + y;

        wr[0] = '{en: go, addr: i1, data: b};
        wr[1] = '{en: go, addr: j1, data: a};
        wr[2] = '{en: go, addr: i2, data: y};
        wr[3] = '{en: go, addr: j2, data: x};

        i_next = i2;
        j_next = j2;
        fetch  = '{z1_addr: sum1, z2_addr: sum2, i2: i2, j2: j2,
                   s1_i2: x, s1_j2: y};
    end

endmodule

// File: rtl/rc4ks_fetch.sv
module rc4ks_fetch
    import rc4ks_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              f_vld,
    input  fetch_t            f,
    input  sym_t              st [SBOX_N],
    output logic              ks_valid,
    output logic [PAIR_W-1:0] ks_data
);

    sym_t z1, z2;

    // The array now holds the double-swapped state; the first byte must see
    // the single-swapped one, so undo the second swap for its address.
    always_comb begin
        z1 = fwd2(f.z1_addr, f.i2, f.s1_i2, f.j2, f.s1_j2, st[f.z1_addr]);
        z2 = st[f.z2_addr];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ks_valid <= 1'b0;
            ks_data  <= '0;
        end else begin
            ks_valid <= f_vld;
            if (f_vld) ks_data <= {z2, z1};
        end
    end

    // R5
    pulse_gap_chk: assert property (@(posedge clk) disable iff (rst)
        ks_valid |=> !ks_valid);

endmodule

// File: rtl/rc4_dual_keystream.sv
module rc4_dual_keystream
    import rc4ks_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              ld_we,
    input  logic [SYM_W-1:0]  ld_addr,
    input  logic [SYM_W-1:0]  ld_data,
    output logic              ks_valid,
    output logic [PAIR_W-1:0] ks_data
);

    sym_t    i_q, j_q, i_n, j_n;
    logic    ph_q, issue, run_ok;
    fetch_t  fetch_n, fetch_q;
    logic    fvld_q;
    wr_req_t wr [WR_PORTS];
    sym_t    st [SBOX_N];

    assign run_ok = en && !ld_we;
    assign issue  = run_ok && !ph_q;

    rc4ks_state_array u_state (
        .clk     (clk),
        .ld_we   (ld_we),
        .ld_addr (ld_addr),
        .ld_data (ld_data),
        .wr      (wr),
        .st      (st)
    );

    rc4ks_round_pair u_round (
        .go      (issue),
        .i_cur   (i_q),
        .j_cur   (j_q),
        .st      (st),
        .wr      (wr),
        .i_next  (i_n),
        .j_next  (j_n),
        .fetch   (fetch_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            i_q     <= '0;
            j_q     <= '0;
            ph_q    <= 1'b0;
            fvld_q  <= 1'b0;
            fetch_q <= '0;
        end else begin
            ph_q   <= run_ok ? !ph_q : 1'b0;
            fvld_q <= issue;
            if (issue) begin
                i_q     <= i_n;
                j_q     <= j_n;
                fetch_q <= fetch_n;
            end
        end
    end

    rc4ks_fetch u_fetch (
        .clk      (clk),
        .rst      (rst),
        .f_vld    (fvld_q),
        .f        (fetch_q),
        .st       (st),
        .ks_valid (ks_valid),
        .ks_data  (ks_data)
    );

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (i_q == '0 && j_q == '0 && !ks_valid));

    // R3
    index_step_chk: assert property (@(posedge clk) disable iff (rst)
        issue |=> (i_q == sym_t'($past(i_q) + sym_t'(2))));

    // R4
    valid_after_issue_chk: assert property (@(posedge clk) disable iff (rst)
        ks_valid |-> $past(issue, 2));

    // R6
    freeze_chk: assert property (@(posedge clk) disable iff (rst)
        !issue |=> ($stable(i_q) && $stable(j_q)));

    // R2
    load_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        ld_we |=> $stable(i_q));

endmodule

// File: tb/sim_rc4_dual_keystream.sv
module sim_rc4_dual_keystream;
    import rc4ks_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        ld_we = 1'b0;
    logic [7:0]  ld_addr = '0;
    logic [7:0]  ld_data = '0;
    logic        ks_valid;
    logic [15:0] ks_data;

    always #10 clk = ~clk;

    rc4_dual_keystream u0 (
        .clk(clk), .rst(rst), .en(en), .ld_we(ld_we),
        .ld_addr(ld_addr), .ld_data(ld_data),
        .ks_valid(ks_valid), .ks_data(ks_data)
    );

    int          checks = 0;
    int          errors = 0;
    int          vcount = 0;
    logic [7:0]  ref_s [256];
    logic [7:0]  perm  [256];
    logic [7:0]  ri, rj;
    logic [15:0] expq [$];
    logic [15:0] mon_e;
    logic [15:0] last_word = '0;
    logic        prev_v = 1'b0;
    string       cur_req = "R3";

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // sequential single-round reference
    function automatic logic [7:0] ref_next();
        logic [7:0] t;
        ri = ri + 8'd1;
        rj = rj + ref_s[ri];
        t = ref_s[ri];
        ref_s[ri] = ref_s[rj];
        ref_s[rj] = t;
        return ref_s[8'(ref_s[ri] + ref_s[rj])];
    endfunction

    function automatic logic [15:0] ref_pair();
        logic [7:0] z1, z2;
        z1 = ref_next();
        z2 = ref_next();
        return {z2, z1};
    endfunction

    // monitor: pops expectations as words appear
    always @(posedge clk) begin
        #1;
        if (!rst) begin
            if (ks_valid) begin
                vcount++;
                last_word = ks_data;
                chk(!prev_v, "R5", 32'(prev_v), 32'd0);
                if (expq.size() == 0) begin
                    chk(1'b0, "R6", 32'(ks_data), 32'hFFFFFFFF);
                end else begin
                    mon_e = expq.pop_front();
                    chk(ks_data == mon_e, cur_req, 32'(ks_data), 32'(mon_e));
                end
            end
            prev_v = ks_valid;
        end else begin
            prev_v = 1'b0;
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; en = 1'b0; ld_we = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        ri = '0; rj = '0;
        expq.delete();
    endtask

    task automatic make_ksa(input int klen, input int seed);
        logic [7:0] j, t, kb;
        for (int a = 0; a < 256; a++) perm[a] = 8'(a);
        j = '0;
        for (int a = 0; a < 256; a++) begin
            if (seed < 0) kb = (a % 3 == 0) ? 8'h4B : (a % 3 == 1) ? 8'h65 : 8'h79;
            else          kb = 8'((a % klen) * 37 + seed);
            j = j + perm[a] + kb;
            t = perm[a]; perm[a] = perm[j]; perm[j] = t;
        end
    endtask

    task automatic load_perm(input bit hold_en);
        for (int a = 0; a < 256; a++) begin
            ld_we = 1'b1; ld_addr = 8'(a); ld_data = perm[a];
            ref_s[a] = perm[a];
            en = hold_en;
            @(negedge clk);
        end
        ld_we = 1'b0; en = 1'b0;
    endtask

    task automatic run(input int n, input int gap);
        for (int k = 0; k < n; k++) begin
            en = 1'b1;
            expq.push_back(ref_pair());
            @(negedge clk);
            @(negedge clk);
            if (gap > 0) begin
                en = 1'b0;
                repeat (gap) @(negedge clk);
            end
        end
        en = 1'b0;
    endtask

    task automatic drain();
        en = 1'b0;
        repeat (4) @(negedge clk);
        chk(expq.size() == 0, "R6", 32'(expq.size()), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R6 watchdog actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int v0;
        do_reset();
        // R1: reset state and idle silence
        @(posedge clk); #2;
        chk(ks_valid == 1'b0, "R1", 32'(ks_valid), 32'd0);
        v0 = vcount;
        repeat (5) @(negedge clk);
        chk(vcount == v0, "R1", 32'(vcount - v0), 32'd0);

        // known vector from key 4B 65 79
        make_ksa(3, -1);
        load_perm(1'b0);
        cur_req = "R3";
        @(negedge clk);
        en = 1'b1;
        expq.push_back(ref_pair());
        @(posedge clk); #2;
        chk(ks_valid == 1'b0, "R4", 32'(ks_valid), 32'd0);
        @(posedge clk); #2;
        chk(ks_valid == 1'b1, "R4", 32'(ks_valid), 32'd1);
        @(negedge clk);
        en = 1'b0;
        repeat (2) @(negedge clk);
        chk(last_word == 16'h9FEB, "R3", 32'(last_word), 32'h9FEB);
        run(1, 2);
        chk(last_word == 16'h8177, "R3", 32'(last_word), 32'h8177);

        // R5: continuous enable
        cur_req = "R5";
        v0 = vcount;
        run(200, 0);
        repeat (3) @(negedge clk);
        chk(vcount - v0 == 200, "R5", 32'(vcount - v0), 32'd200);

        // R6: gaps and single-cycle enables
        cur_req = "R6";
        run(60, 3);
        for (int k = 0; k < 20; k++) begin
            en = 1'b1;
            expq.push_back(ref_pair());
            @(negedge clk);
            en = 1'b0;
            repeat (2) @(negedge clk);
        end
        run(40, 0);
        drain();

        // R2: loading with en held high starts nothing
        do_reset();
        for (int a = 0; a < 256; a++) perm[a] = 8'(a);
        cur_req = "R2";
        v0 = vcount;
        load_perm(1'b1);
        repeat (3) @(negedge clk);
        chk(vcount == v0, "R2", 32'(vcount - v0), 32'd0);
        cur_req = "R7";
        run(300, 1);
        drain();

        // R7: j2 == i1 in the first iteration
        do_reset();
        for (int a = 0; a < 256; a++) perm[a] = 8'(a);
        perm[1] = 8'd5;   perm[5] = 8'd1;
        perm[2] = 8'd252; perm[252] = 8'd2;
        load_perm(1'b0);
        run(150, 0);
        drain();

        // R7: i2 == j1 in the first iteration
        do_reset();
        for (int a = 0; a < 256; a++) perm[a] = 8'(a);
        perm[1] = 8'd2; perm[2] = 8'd1;
        load_perm(1'b0);
        run(150, 2);
        drain();

        // R3: longer scheduled key
        do_reset();
        make_ksa(13, 11);
        load_perm(1'b0);
        cur_req = "R3";
        run(400, 0);
        drain();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule